// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog that escalates through four timeout stages in a fixed order. Each stage has its own threshold, counted in watchdog ticks, and its own action. The action is one of: do nothing, raise an interrupt, pulse the CPU reset, or pulse the system reset. A programmable prescaler sets how many clock cycles make one tick. When the active stage times out, its action is carried out and the next stage starts from a zero count. After the last stage the sequence wraps to the first.

Software reaches the block through a simple word-addressed write port and a combinational read port. The control, prescale and threshold registers accept writes only while the block is unlocked. Writing the unlock key to the key register unlocks it, and writing any other value there locks it again. The feed register and the interrupt-clear register are always writable, so a locked system can still feed the watchdog.

A reset action drives its reset output for a programmable number of clock cycles. It also clears the enable bit, which halts the watchdog until software enables it again.

Top module: `wdg_top`

## Requirements
- R1: After reset, irq, cpuRst and sysRst are low and the block is locked (address 7 reads 0). Control (address 0) reads 0x7E00 and prescale (address 1) reads 1. Thresholds (addresses 2 to 5) read 0.
- R2: Writing KEY to address 7 unlocks the block, and address 7 then reads 1. Writing any other value to address 7 locks it. While the block is locked, writes to addresses 0 to 5 have no effect.
- R3: Let P = max(prescale, 1) and Tk = max(threshold k, 1). With the block enabled, stage k times out Tk*P cycles after it starts. Stage k+1 starts at that same edge. Stage 3 is followed by stage 0.
- R4: Control bits [2k+2:2k+1] give the action of stage k: 0 off, 1 interrupt, 2 CPU reset, 3 system reset. An off stage still times out and advances, but drives no output.
- R5: An interrupt action sets a sticky raw flag, which reads as bit 0 of address 8. The irq output equals the raw flag AND control bit 15. Writing 1 in bit 0 of address 8 clears the flag, and writing 0 there leaves it unchanged.
- R6: A CPU reset action drives cpuRst high for (control[11:9]+1)*RST_UNIT cycles. A system reset action drives sysRst high for (control[14:12]+1)*RST_UNIT cycles. Either action clears control bit 0, and the watchdog produces no further output until software enables it again.
- R7: A write of any value to address 6 restarts the sequence at stage 0 with zero tick and prescale counts, so stage 0 times out T0*P cycles after that write. The write works while the block is locked, and it takes priority over a timeout in the same cycle.
- R8: Control bit 0 enables the watchdog. While the bit is 0, the stage and all counts are held at zero. Enabling the watchdog starts stage 0 afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write word address |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Read word address |
| rdData | output | 32 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| cpuRst | output | 1 | CPU reset pulse |
| sysRst | output | 1 | System reset pulse |

## Verification
The assertions assume one write per cycle on the register port, with address and data stable for that whole cycle. They also assume that software does not set the enable bit in the same cycle as a reset action. The stimulus respects both assumptions: every write is issued from a task that holds the strobe for exactly one clock. Software never enables the block until the reset pulse has finished and the enable bit has been read back as zero.

The sweeps keep thresholds and prescale values small. Stages that are not under test get a large threshold, so that they do not time out during a measurement window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int NUM_STG = 4;
  localparam int STG_W   = 2;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRE  = 4'd1;
  localparam int                A_THR0 = 2;
  localparam logic [ADDR_W-1:0] A_FEED = 4'd6;
  localparam logic [ADDR_W-1:0] A_KEY  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ICLR = 4'd8;

  typedef enum logic [1:0] {
    ACT_OFF = 2'd0,
    ACT_IRQ = 2'd1,
    ACT_CPU = 2'd2,
    ACT_SYS = 2'd3
  } act_e;

  typedef struct packed {
    logic                      irqEn;
    logic [2:0]                sysLen;
    logic [2:0]                cpuLen;
    logic [NUM_STG-1:0][1:0]   act;
    logic                      en;
  } cfg_t;

  localparam int   CFG_W   = $bits(cfg_t);
  localparam cfg_t CFG_RST = '{irqEn: 1'b0, sysLen: 3'd7, cpuLen: 3'd7, act: '0, en: 1'b0};

  // control -> datapath
  typedef struct packed {
    logic clrAll;
    logic clrTick;
    logic setIrq;
    logic fireCpu;
    logic fireSys;
    logic dropEn;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic enabled;
    logic feed;
    logic expired;
    act_e curAct;
  } status_t;
endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          TH_W     = 32,
  parameter int          PRE_W    = 16,
  parameter int          RST_UNIT = 4,
  parameter logic [31:0] KEY      = 32'hA5C3_0F1E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  strobe_t           strb,
  input  logic [STG_W-1:0]  stage,
  output status_t           st,
  output logic              irq,
  output logic              cpuRst,
  output logic              sysRst
);
  localparam int PULSE_MAX = 8 * RST_UNIT;
  localparam int PULSE_W   = $clog2(PULSE_MAX + 1);

  logic              unlocked;
  cfg_t              cfg;
  logic [PRE_W-1:0]  pre, preCnt, preLim;
  logic [TH_W-1:0]   thr [NUM_STG];
  logic [TH_W-1:0]   tickCnt, thrCur;
  logic              tick, expired, cfgWr, clrHit;
  logic              irqRaw;
  logic [PULSE_W-1:0] cpuCnt, sysCnt;

  assign cfgWr  = wrEn && unlocked;
  assign clrHit = wrEn && (wrAddr == A_ICLR) && wrData[0];

  function automatic logic [PULSE_W-1:0] lenCycles(input logic [2:0] len);
    return PULSE_W'((int'(len) + 1) * RST_UNIT);
  endfunction

  // key register: always writable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unlocked <= 1'b0;
    else if (wrEn && wrAddr == A_KEY) unlocked <= (wrData[31:0] == KEY);
  end

  // protected control and prescale registers; hardware may drop enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= CFG_RST;
      pre <= PRE_W'(1);
    end else begin
      if (cfgWr && wrAddr == A_CTRL) cfg <= cfg_t'(wrData[CFG_W-1:0]);
      if (cfgWr && wrAddr == A_PRE)  pre <= wrData[PRE_W-1:0];
      if (strb.dropEn)               cfg.en <= 1'b0;
    end
  end

  // per-stage thresholds
  for (genvar g = 0; g < NUM_STG; g++) begin : gThr
    localparam logic [ADDR_W-1:0] THR_ADDR = ADDR_W'(A_THR0 + g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) thr[g] <= '0;
      else if (cfgWr && wrAddr == THR_ADDR) thr[g] <= wrData[TH_W-1:0];
    end
  end

  // prescaler
  assign preLim = (pre == '0) ? '0 : pre - 1'b1;
  assign tick   = cfg.en && (preCnt == preLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preCnt <= '0;
    else if (strb.clrAll) preCnt <= '0;
    else if (cfg.en)      preCnt <= tick ? '0 : preCnt + 1'b1;
  end

  // tick counter and threshold compare
  assign thrCur  = thr[stage];
  assign expired = tick && (({1'b0, tickCnt} + 1'b1) >= {1'b0, thrCur});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           tickCnt <= '0;
    else if (strb.clrAll || strb.clrTick) tickCnt <= '0;
    else if (tick)                       tickCnt <= tickCnt + 1'b1;
  end

  // sticky interrupt flag, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            irqRaw <= 1'b0;
    else if (strb.setIrq) irqRaw <= 1'b1;
    else if (clrHit)      irqRaw <= 1'b0;
  end
  assign irq = irqRaw & cfg.irqEn;

  // reset pulse stretchers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuCnt <= '0;
      sysCnt <= '0;
    end else begin
      if (strb.fireCpu)      cpuCnt <= lenCycles(cfg.cpuLen);
      else if (cpuCnt != '0) cpuCnt <= cpuCnt - 1'b1;
      if (strb.fireSys)      sysCnt <= lenCycles(cfg.sysLen);
      else if (sysCnt != '0) sysCnt <= sysCnt - 1'b1;
    end
  end
  assign cpuRst = (cpuCnt != '0);
  assign sysRst = (sysCnt != '0);

  assign st.enabled = cfg.en;
  assign st.feed    = wrEn && (wrAddr == A_FEED);
  assign st.expired = expired;
  assign st.curAct  = act_e'(cfg.act[stage]);

  // read mux
  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL:  rdData = DATA_W'(cfg);
      A_PRE:   rdData = DATA_W'(pre);
      A_KEY:   rdData = DATA_W'(unlocked);
      A_ICLR:  rdData = DATA_W'(irqRaw);
      default: rdData = '0;
    endcase
    for (int i = 0; i < NUM_STG; i++)
      if (rdAddr == ADDR_W'(A_THR0 + i)) rdData = DATA_W'(thr[i]);
  end

  // locked writes leave the control register alone
  p_lock_guard_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !unlocked && wrAddr == A_CTRL && !strb.dropEn) |=> (cfg == $past(cfg)));

  // interrupt flag stays until an explicit clear
  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqRaw && !clrHit) |=> irqRaw);

  // a reset action halts the watchdog
  p_rst_halts_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fireCpu || strb.fireSys) |=> !cfg.en);

  // cpu reset pulse only starts from a cpu reset action
  p_cpu_origin_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRst) |-> $past(strb.fireCpu));

  p_sys_origin_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRst) |-> $past(strb.fireSys));
endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  status_t          st,
  output strobe_t          strb,
  output logic [STG_W-1:0] stage
);
  logic [STG_W-1:0] stageNext;

  always_comb begin
    strb      = '0;
    stageNext = stage;
    if (!st.enabled) begin
      strb.clrAll = 1'b1;
      stageNext   = '0;
    end else if (st.feed) begin
      strb.clrAll = 1'b1;
      stageNext   = '0;
    end else if (st.expired) begin
      strb.clrTick = 1'b1;
      stageNext    = stage + 1'b1;
      case (st.curAct)
        ACT_IRQ: strb.setIrq = 1'b1;
        ACT_CPU: begin
          strb.fireCpu = 1'b1;
          strb.dropEn  = 1'b1;
          stageNext    = '0;
        end
        ACT_SYS: begin
          strb.fireSys = 1'b1;
          strb.dropEn  = 1'b1;
          stageNext    = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= stageNext;
  end

  p_feed_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.enabled && st.feed) |=> (stage == '0));

  p_stage_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.enabled && !st.feed && st.expired && (st.curAct == ACT_OFF || st.curAct == ACT_IRQ))
      |=> (stage == STG_W'($past(stage) + 1'b1)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !st.enabled |=> (stage == '0));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          TH_W     = 32,
  parameter int          PRE_W    = 16,
  parameter int          RST_UNIT = 4,
  parameter logic [31:0] KEY      = 32'hA5C3_0F1E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              cpuRst,
  output logic              sysRst
);
  strobe_t          strb;
  status_t          st;
  logic [STG_W-1:0] stage;

  wdg_datapath #(
    .DATA_W(DATA_W), .TH_W(TH_W), .PRE_W(PRE_W), .RST_UNIT(RST_UNIT), .KEY(KEY)
  ) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strb(strb), .stage(stage), .st(st),
    .irq(irq), .cpuRst(cpuRst), .sysRst(sysRst)
  );

  wdg_control uCtl (
    .clk(clk), .rstN(rstN), .st(st), .strb(strb), .stage(stage)
  );
endmodule

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  localparam logic [31:0] KEY = 32'hA5C3_0F1E;
  localparam int U = 4;
  localparam logic [3:0] AC = 0, AP = 1, AT0 = 2, AT1 = 3, AT2 = 4, AT3 = 5,
                         AF = 6, AK = 7, AI = 8;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [3:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic irq, cpuRst, sysRst;
  int cyc = 0, total = 0, bad = 0;

  wdg_top #(.RST_UNIT(U), .KEY(KEY)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq), .cpuRst(cpuRst), .sysRst(sysRst)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  function automatic logic [31:0] mk(bit en, bit [1:0] a0, a1, a2, a3,
                                     bit [2:0] cl, sl, bit ie);
    return {16'd0, ie, sl, cl, a3, a2, a1, a0, en};
  endfunction

  function automatic logic sel(int w);
    return (w == 0) ? irq : (w == 1) ? cpuRst : sysRst;
  endfunction

  task automatic waitSig(int w, int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sel(w)) begin at = cyc; break; end
    end
  endtask

  task automatic arm(int p, int t0, int t1, int t2, int t3, logic [31:0] ctl, output int c0);
    wr(AK, KEY);
    wr(AC, ctl & ~32'd1);
    wr(AI, 32'd1);
    wr(AP, p); wr(AT0, t0); wr(AT1, t1); wr(AT2, t2); wr(AT3, t3);
    wr(AC, ctl | 32'd1);
    c0 = cyc;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c0, at, n;
    bit seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {irq, cpuRst, sysRst}, 0);
    rd(AC, d); chk("R1 ctrl", d, 32'h7E00);
    rd(AP, d); chk("R1 prescale", d, 1);
    rd(AK, d); chk("R1 locked", d, 0);
    rd(AT2, d); chk("R1 thr", d, 0);

    // R2 key protection
    wr(AT0, 32'h55); rd(AT0, d); chk("R2 locked thr write", d, 0);
    wr(AK, KEY); rd(AK, d); chk("R2 unlock", d, 1);
    wr(AT0, 5); rd(AT0, d); chk("R2 unlocked thr write", d, 5);
    wr(AK, 32'h1234); rd(AK, d); chk("R2 relock", d, 0);
    wr(AC, 32'h1); rd(AC, d); chk("R2 locked ctrl write", d, 32'h7E00);

    // R3 sweep of prescale and threshold, stage 0 interrupt
    for (int p = 1; p <= 3; p++)
      for (int t = 1; t <= 3; t++) begin
        arm(p, t, 1000, 1000, 1000, mk(0, 1, 1, 1, 1, 0, 0, 1), c0);
        waitSig(0, 100, at);
        chk($sformatf("R3 p=%0d t=%0d", p, t), at - c0, p * t);
      end

    // R3 stage order and wrap, all interrupt
    arm(2, 1, 2, 3, 4, mk(0, 1, 1, 1, 1, 0, 0, 1), c0);
    n = 0;
    for (int k = 0; k < 5; k++) begin
      waitSig(0, 100, at);
      n += 2 * ((k == 4) ? 1 : k + 1);
      chk($sformatf("R3 expiry %0d", k), at - c0, n);
      wr(AI, 1);
    end

    // R4 off stage is silent but advances
    arm(1, 3, 2, 1000, 1000, mk(0, 0, 1, 0, 0, 0, 0, 1), c0);
    waitSig(0, 100, at);
    chk("R4 off then irq", at - c0, 5);

    // R5 mask and clear
    arm(1, 2, 1000, 1000, 1000, mk(0, 1, 0, 0, 0, 0, 0, 0), c0);
    repeat (4) @(negedge clk);
    chk("R5 masked irq", irq, 0);
    rd(AI, d); chk("R5 raw flag", d, 1);
    wr(AC, mk(1, 1, 0, 0, 0, 0, 0, 1));
    chk("R5 unmasked irq", irq, 1);
    wr(AI, 0); rd(AI, d); chk("R5 clear with 0", d, 1);
    wr(AI, 1); rd(AI, d); chk("R5 clear with 1", d, 0);
    chk("R5 irq low after clear", irq, 0);

    // R6 cpu reset pulse
    arm(1, 2, 1, 1000, 1000, mk(0, 2, 1, 0, 0, 2, 0, 1), c0);
    waitSig(1, 100, at);
    chk("R6 cpu rst time", at - c0, 2);
    n = 1; seen = 0;
    while (n < 200) begin
      @(negedge clk);
      if (sysRst) seen = 1;
      if (!cpuRst) break;
      n++;
    end
    chk("R6 cpu width", n, 3 * U);
    chk("R6 no sys rst", seen, 0);
    rd(AC, d); chk("R6 enable cleared", d[0], 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq || cpuRst || sysRst) seen = 1;
    end
    chk("R6 halted", seen, 0);

    // R6 system reset pulse after an off stage
    arm(3, 1, 2, 1000, 1000, mk(0, 0, 3, 0, 0, 0, 0, 1), c0);
    waitSig(2, 100, at);
    chk("R6 sys rst time", at - c0, 9);
    n = 1;
    while (n < 200) begin
      @(negedge clk);
      if (!sysRst) break;
      n++;
    end
    chk("R6 sys width", n, U);

    // R7 feed while locked
    arm(2, 5, 1000, 1000, 1000, mk(0, 1, 0, 0, 0, 0, 0, 1), c0);
    repeat (6) @(negedge clk);
    wr(AK, 0);
    wr(AF, 0);
    c0 = cyc;
    waitSig(0, 100, at);
    chk("R7 feed restart", at - c0, 10);
    rd(AK, d); chk("R7 still locked", d, 0);

    // R8 disable clears progress
    arm(1, 4, 1000, 1000, 1000, mk(0, 1, 0, 0, 0, 0, 0, 1), c0);
    repeat (2) @(negedge clk);
    wr(AC, mk(0, 1, 0, 0, 0, 0, 0, 1));
    wr(AC, mk(1, 1, 0, 0, 0, 0, 0, 1));
    c0 = cyc;
    waitSig(0, 100, at);
    chk("R8 re-enable fresh", at - c0, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule